// File: doc/BRIEF.md
# Interrupt request flag controller

This block keeps the pending interrupt flags of a small microcontroller and turns them into one request line for the CPU. Pulses from peripheral event sources set flags in an 8-bit request register. Software reaches that register and a companion 8-bit enable register through a small register bus. Software can read the flags, write them to clear them, or write them to force an interrupt.

When a flag is pending, its enable bit is set and the CPU's master enable input is high, the block raises its request. It also reports the index of the source the CPU should take. When the CPU returns an accept strobe with that index, the block clears the flag. In the default configuration only bit 2 (first timer) and bit 3 (second timer) carry sources. A register write starts a hold-off window that masks the request until the CPU reports one more completed instruction.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the request register and the enable register both read 0x00, and `irq_req` is 0.
- R2: A pulse on a source input whose bit is implemented sets that flag to 1 on the next clock edge. This happens whatever the enable register and `master_en` hold.
- R3: `irq_req` is 1 exactly when some flag and its matching enable bit are both 1, `master_en` is 1, and no hold-off window is open.
- R4: The request register is at bus address 0. A write loads the implemented bits from `bus_wdata`. A 1 sets a flag and can raise a request like a hardware event does, and a 0 clears a flag.
- R5: A cycle with `irq_ack` high clears the flag selected by `ack_idx` on the next clock edge.
- R6: If a source pulse and an accept for the same flag fall in the same cycle, the flag stays 1.
- R7: Request bits other than 2 and 3 always read 0. Writes and source pulses do not change them.
- R8: While `irq_req` is 1, `irq_idx` gives the lowest-numbered bit that is both pending and enabled.
- R9: A write to either register opens a hold-off window. The window closes at the first clock edge after the write where `insn_done` is high. An `insn_done` in the same cycle as the write does not close it.
- R10: The enable register is at bus address 1. It stores and reads back all 8 bits that are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 1 | 0 selects the request register, 1 selects the enable register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register chosen by `bus_addr` |
| src_evt | input | 8 | Source event pulses, one bit per flag |
| master_en | input | 1 | CPU master interrupt enable |
| insn_done | input | 1 | Strobe: one instruction has completed |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 3 | Index of the source to take |
| irq_ack | input | 1 | CPU accept strobe |
| ack_idx | input | 3 | Index of the accepted source |

## Verification
The assertions assume that `src_evt`, `irq_ack` and the bus strobes are sampled as single-cycle pulses at the clock edge. They also assume that `ack_idx` names the source the CPU actually accepted. The checks on accept clearing allow for a simultaneous event on the same bit and do not rely on the CPU accepting only while a request is raised. The bench drives every input on the falling edge, holds each strobe for one cycle, and sends accepts only for indices the block has just reported, except for the one deliberate collision of an event with an accept.

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int W = 8,
  parameter int IDX_W = $clog2(W),
  parameter logic [W-1:0] SRC_MASK = W'(12)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [W-1:0]     bus_wdata,
  output logic [W-1:0]     bus_rdata,
  input  logic [W-1:0]     src_evt,
  input  logic             master_en,
  input  logic             insn_done,
  output logic             irq_req,
  output logic [IDX_W-1:0] irq_idx,
  input  logic             irq_ack,
  input  logic [IDX_W-1:0] ack_idx
);

  logic [W-1:0] flag_q, en_q, flag_d, ack_mask, pend;
  logic         hold_q, wr_flag, wr_en;

  assign wr_flag  = bus_sel & bus_wr & ~bus_addr;
  assign wr_en    = bus_sel & bus_wr &  bus_addr;
  assign ack_mask = irq_ack ? (W'(1) << ack_idx) : '0;
  assign flag_d   = (((wr_flag ? bus_wdata : flag_q) & ~ack_mask) | src_evt) & SRC_MASK;
  assign pend     = flag_q & en_q;
  assign irq_req  = master_en & ~hold_q & (|pend);
  assign bus_rdata = bus_addr ? en_q : flag_q;

  always_comb begin
    irq_idx = '0;
    for (int i = W - 1; i >= 0; i--)
      if (pend[i]) irq_idx = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      hold_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (wr_en) en_q <= bus_wdata;
      if (wr_flag | wr_en) hold_q <= 1'b1;
      else if (insn_done)  hold_q <= 1'b0;
    end
  end

endmodule

module irq_flag_ctrl_chk #(
  parameter int W = 8,
  parameter int IDX_W = 3,
  parameter logic [W-1:0] SRC_MASK = W'(12)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_sel,
  input logic             bus_wr,
  input logic [W-1:0]     src_evt,
  input logic             master_en,
  input logic             irq_req,
  input logic [IDX_W-1:0] irq_idx,
  input logic             irq_ack,
  input logic [IDX_W-1:0] ack_idx,
  input logic [W-1:0]     flag_q,
  input logic [W-1:0]     en_q,
  input logic             hold_q
);

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_evt & SRC_MASK) != '0) |=> ((flag_q & $past(src_evt & SRC_MASK)) == $past(src_evt & SRC_MASK)));

  assert_req_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (master_en && !hold_q && ((flag_q & en_q) != '0)));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !src_evt[ack_idx]) |=> !flag_q[$past(ack_idx)]);

  assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & ~SRC_MASK) == '0);

  assert_lowest_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (((flag_q & en_q) >> irq_idx) & W'(1)) != '0 &&
                ((flag_q & en_q) & ((W'(1) << irq_idx) - W'(1))) == '0);

  assert_write_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr) |=> !irq_req);

endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk #(.W(W), .IDX_W(IDX_W), .SRC_MASK(SRC_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .src_evt(src_evt),
  .master_en(master_en), .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack),
  .ack_idx(ack_idx), .flag_q(flag_q), .en_q(en_q), .hold_q(hold_q)
);

// File: tb/test_irq_flag_ctrl.sv
`timescale 1ns/1ps
module test_irq_flag_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata, src_evt = 0;
  logic       master_en = 0, insn_done = 0, irq_req, irq_ack = 0;
  logic [2:0] irq_idx, ack_idx = 0;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl i_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt), .master_en(master_en),
    .insn_done(insn_done), .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack),
    .ack_idx(ack_idx)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr(logic a, logic [7:0] d, logic done = 0);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; insn_done = done;
    cyc();
    bus_sel = 0; bus_wr = 0; insn_done = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    bus_addr = a; #0.5; d = bus_rdata;
  endtask

  task automatic evt(logic [7:0] m, logic ack = 0, logic [2:0] ai = 0);
    src_evt = m; irq_ack = ack; ack_idx = ai;
    cyc();
    src_evt = 0; irq_ack = 0;
  endtask

  task automatic done(); insn_done = 1; cyc(); insn_done = 0; endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); check("R1 req reg", d, 8'h00);
    rd(1, d); check("R1 en reg", d, 8'h00);
    check("R1 irq_req", irq_req, 0);
  endtask

  task automatic t_event_sets();
    logic [7:0] d;
    evt(8'h04);
    rd(0, d); check("R2 timer flag set with enables off", d, 8'h04);
    check("R3 no req when disabled", irq_req, 0);
  endtask

  task automatic t_gate_and_hold();
    logic [7:0] d;
    master_en = 1;
    wr(1, 8'h04);
    rd(1, d); check("R10 en readback", d, 8'h04);
    check("R9 held after en write", irq_req, 0);
    cyc();
    check("R9 still held without insn_done", irq_req, 0);
    done();
    check("R3 req after insn_done", irq_req, 1);
    check("R8 idx timer A", irq_idx, 2);
    master_en = 0; #0.5;
    check("R3 master off", irq_req, 0);
    master_en = 1; #0.5;
  endtask

  task automatic t_ack();
    logic [7:0] d;
    evt(8'h00, 1, 3'd2);
    rd(0, d); check("R5 flag cleared by ack", d, 8'h00);
    check("R5 req dropped", irq_req, 0);
  endtask

  task automatic t_sw_set_and_order();
    logic [7:0] d;
    wr(1, 8'h0C); done();
    wr(0, 8'h08, 1);
    check("R9 insn_done with write keeps hold", irq_req, 0);
    done();
    check("R4 software set raises req", irq_req, 1);
    check("R4 idx timer B", irq_idx, 3);
    evt(8'h04);
    check("R8 lowest wins", irq_idx, 2);
    evt(8'h00, 1, 3'd2);
    check("R8 next source after ack", irq_idx, 3);
    check("R8 req stays", irq_req, 1);
    wr(0, 8'h00); done();
    rd(0, d); check("R4 write zero clears", d, 8'h00);
    check("R4 req gone", irq_req, 0);
  endtask

  task automatic t_unused_bits();
    logic [7:0] d;
    wr(0, 8'hFF); done();
    rd(0, d); check("R7 only timer bits take writes", d, 8'h0C);
    wr(0, 8'h00); done();
    evt(8'hF3);
    rd(0, d); check("R7 events on unused bits ignored", d, 8'h00);
    check("R7 no req", irq_req, 0);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    evt(8'h08);
    evt(8'h08, 1, 3'd3);
    rd(0, d); check("R6 set beats ack", d, 8'h08);
    evt(8'h00, 1, 3'd3);
    rd(0, d); check("R6 later ack clears", d, 8'h00);
  endtask

  task automatic t_enable_full();
    logic [7:0] d;
    wr(1, 8'hA5); done();
    rd(1, d); check("R10 all enable bits stored", d, 8'hA5);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    rst_n = 1; cyc();
    t_event_sets();
    t_gate_and_hold();
    t_ack();
    t_sw_set_and_order();
    t_unused_bits();
    t_collision();
    t_enable_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule